// File: doc/BRIEF.md
# Accumulator Execute Stage with Arithmetic Flags

This block is the execute stage of a small 8-bit accumulator machine. It covers two operations, add and bitwise AND, and each comes in two operand forms. The immediate form combines the working register with an 8-bit literal. The file form combines the working register with a byte read from data memory at a 7-bit address. The block holds the working register and the three status flags: carry, digit carry and zero. Instruction fetch, decode of the full instruction word, memory banking and the data memory itself sit outside the block.

Each cycle the decoder presents an operation code, the literal, the file address, a destination bit and the byte read from the file. The block forms the result combinationally. It drives a file write strobe with the address and data in the same cycle, so the external memory captures the write on the next clock edge. On that same edge the block updates its working register and flags. Add operations refresh all three flags. AND operations refresh only the zero flag.

Top module: `acc_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears the working register, carry, digit carry and zero to 0, and no file write is strobed while the operation code is 0.
- R2: Operation code 1 (add immediate) loads the working register with (W + literal) mod 256 on the next edge, and `alu_result` shows that value in the same cycle.
- R3: Operation code 2 (AND immediate) loads the working register with W AND literal on the next edge.
- R4: Operation codes 3 (add file) and 4 (AND file) take their second operand from `file_rdata`. With `dest_file` = 0 the result goes to the working register and `file_we` stays 0.
- R5: For operation codes 3 and 4 with `dest_file` = 1, `file_we` is 1, `file_waddr` equals `file_addr`, `file_wdata` equals the result, and the working register keeps its value.
- R6: The immediate operations (codes 1 and 2) never assert `file_we`, whatever the value of `dest_file`.
- R7: After an add (code 1 or 3), carry holds the carry out of bit 7 of the 8-bit sum.
- R8: After an add, digit carry holds the carry out of bit 3, which is the carry of the low-nibble addition.
- R9: After any of codes 1 to 4, zero is 1 exactly when the 8-bit result is 0.
- R10: After an AND (code 2 or 4), carry and digit carry keep their previous values.
- R11: Operation codes 0, 5, 6 and 7 are idle. They change neither the working register nor any flag, and they do not assert `file_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 3 | Operation code: 0 idle, 1 add immediate, 2 AND immediate, 3 add file, 4 AND file, 5-7 idle |
| literal | input | 8 | Immediate operand |
| file_addr | input | 7 | Address of the file operand |
| dest_file | input | 1 | File forms only: 0 writes the working register, 1 writes the file |
| file_rdata | input | 8 | Byte read from the addressed file register |
| alu_result | output | 8 | Combinational result of the current operation |
| file_we | output | 1 | File write strobe, captured by memory on the next edge |
| file_waddr | output | 7 | File write address |
| file_wdata | output | 8 | File write data |
| w_reg | output | 8 | Working register |
| flag_c | output | 1 | Carry flag |
| flag_dc | output | 1 | Digit carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
The result, `file_we`, `file_waddr` and `file_wdata` depend only on the inputs and the state, so they are due in the same cycle the operation is presented. The bench samples them at the falling edge of that cycle. The working register and the flags are due one rising edge later, so the scoreboard holds each popped item for one more falling edge and compares the registered state there. The expected state comes from a model in the bench that advances once per driven operation, in the same order.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OPC_IDLE    = 3'd0,
      OPC_ADD_IMM = 3'd1,
      OPC_AND_IMM = 3'd2,
      OPC_ADD_FIL = 3'd3,
      OPC_AND_FIL = 3'd4
   } opc_e;

   typedef struct packed {
      logic active;     // one of the four real operations
      logic is_add;     // add (else AND)
      logic from_file;  // operand comes from file read data
   } op_dec_t;

   function automatic op_dec_t decode_op(input logic [OP_W-1:0] code);
      op_dec_t d;
      d = '0;
      case (code)
         OPC_ADD_IMM: begin d.active = 1'b1; d.is_add = 1'b1; end
         OPC_AND_IMM: begin d.active = 1'b1; end
         OPC_ADD_FIL: begin d.active = 1'b1; d.is_add = 1'b1; d.from_file = 1'b1; end
         OPC_AND_FIL: begin d.active = 1'b1; d.from_file = 1'b1; end
         default:     d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/acc_adder.sv
module acc_adder #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum,
   output logic              carry_out,
   output logic              nib_carry
);

   generate
      if (NIB_W < 1 || NIB_W >= DATA_W) begin : g_bad_nib
         $error("acc_adder: NIB_W must lie strictly between 0 and DATA_W");
      end

      if (RIPPLE) begin : g_ripple
         logic [DATA_W:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
         end
         assign carry_out = cy[DATA_W];
         assign nib_carry = cy[NIB_W];
      end else begin : g_behav
         logic [NIB_W:0]  low_sum;
         logic [DATA_W:0] full_sum;
         assign full_sum  = {1'b0, a} + {1'b0, b};
         assign low_sum   = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]};
         assign sum       = full_sum[DATA_W-1:0];
         assign carry_out = full_sum[DATA_W];
         assign nib_carry = low_sum[NIB_W];
      end
   endgenerate

endmodule

// File: rtl/acc_logic.sv
module acc_logic #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] conj
);

   for (genvar i = 0; i < DATA_W; i++) begin : g_and
      assign conj[i] = a[i] & b[i];
   end

endmodule

// File: rtl/acc_flag_reg.sv
module acc_flag_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              upd_arith,
   input  logic              upd_zero,
   input  logic              new_c,
   input  logic              new_dc,
   input  logic [DATA_W-1:0] result,
   output logic              c_q,
   output logic              dc_q,
   output logic              z_q
);

   logic res_zero;
   assign res_zero = (result == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         c_q  <= 1'b0;
         dc_q <= 1'b0;
         z_q  <= 1'b0;
      end else begin
         if (upd_arith) begin
            c_q  <= new_c;
            dc_q <= new_dc;
         end
         if (upd_zero) begin
            z_q <= res_zero;
         end
      end
   end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7,
   parameter int NIB_W  = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] literal,
   input  logic [ADDR_W-1:0] file_addr,
   input  logic              dest_file,
   input  logic [DATA_W-1:0] file_rdata,
   output logic [DATA_W-1:0] alu_result,
   output logic              file_we,
   output logic [ADDR_W-1:0] file_waddr,
   output logic [DATA_W-1:0] file_wdata,
   output logic [DATA_W-1:0] w_reg,
   output logic              flag_c,
   output logic              flag_dc,
   output logic              flag_z
);
   import acc_exec_pkg::*;

   localparam int NIB_CNT = DATA_W / NIB_W;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("acc_exec_unit: DATA_W too small");
      end
      if (NIB_CNT < 1) begin : g_bad_cnt
         $error("acc_exec_unit: NIB_W exceeds DATA_W");
      end
      if (ADDR_W < 1) begin : g_bad_a
         $error("acc_exec_unit: ADDR_W must be positive");
      end
   endgenerate

   op_dec_t           dec;
   logic [DATA_W-1:0] operand_b;
   logic [DATA_W-1:0] add_sum;
   logic [DATA_W-1:0] and_out;
   logic              add_cy;
   logic              add_dc;
   logic              to_file;
   logic              w_load;

   assign dec       = decode_op(op_sel);
   assign operand_b = dec.from_file ? file_rdata : literal;

   acc_adder #(
      .DATA_W (DATA_W),
      .NIB_W  (NIB_W),
      .RIPPLE (RIPPLE)
   ) u_adder (
      .a         (w_reg),
      .b         (operand_b),
      .sum       (add_sum),
      .carry_out (add_cy),
      .nib_carry (add_dc)
   );

   acc_logic #(
      .DATA_W (DATA_W)
   ) u_logic (
      .a    (w_reg),
      .b    (operand_b),
      .conj (and_out)
   );

   assign alu_result = dec.is_add ? add_sum : and_out;

   // destination routing
   assign to_file    = dec.active & dec.from_file & dest_file;
   assign w_load     = dec.active & ~to_file;
   assign file_we    = to_file;
   assign file_waddr = file_addr;
   assign file_wdata = alu_result;

   always_ff @(posedge clk) begin
      if (rst) begin
         w_reg <= '0;
      end else if (w_load) begin
         w_reg <= alu_result;
      end
   end

   acc_flag_reg #(
      .DATA_W (DATA_W)
   ) u_flags (
      .clk       (clk),
      .rst       (rst),
      .upd_arith (dec.active & dec.is_add),
      .upd_zero  (dec.active),
      .new_c     (add_cy),
      .new_dc    (add_dc),
      .result    (alu_result),
      .c_q       (flag_c),
      .dc_q      (flag_dc),
      .z_q       (flag_z)
   );

endmodule

// File: rtl/acc_exec_checker.sv
module acc_exec_checker #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst,
   input logic [2:0]        op_sel,
   input logic              dest_file,
   input logic [ADDR_W-1:0] file_addr,
   input logic [DATA_W-1:0] alu_result,
   input logic              file_we,
   input logic [ADDR_W-1:0] file_waddr,
   input logic [DATA_W-1:0] w_reg,
   input logic              flag_c,
   input logic              flag_dc,
   input logic              flag_z
);

   logic chk_idle, chk_and, chk_file, chk_real;
   assign chk_real = (op_sel >= 3'd1) && (op_sel <= 3'd4);
   assign chk_idle = !chk_real;
   assign chk_and  = (op_sel == 3'd2) || (op_sel == 3'd4);
   assign chk_file = (op_sel == 3'd3) || (op_sel == 3'd4);

   AST_WE_ONLY_FILE_DEST: assert property (@(posedge clk) disable iff (rst)
      file_we |-> (chk_file && dest_file)); // R6

   AST_WE_ADDR: assert property (@(posedge clk) disable iff (rst)
      file_we |-> (file_waddr == file_addr)); // R5

   AST_FILE_DEST_W_HOLD: assert property (@(posedge clk) disable iff (rst)
      (chk_file && dest_file) |=> $stable(w_reg)); // R5

   AST_W_LOADS_RESULT: assert property (@(posedge clk) disable iff (rst)
      (chk_real && !(chk_file && dest_file)) |=> (w_reg == $past(alu_result))); // R2

   AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
      chk_real |=> (flag_z == ($past(alu_result) == '0))); // R9

   AST_AND_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
      chk_and |=> ($stable(flag_c) && $stable(flag_dc))); // R10

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      chk_idle |=> ($stable(w_reg) && $stable(flag_c) && $stable(flag_dc) && $stable(flag_z))); // R11

   AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (rst)
      chk_idle |-> !file_we); // R11

endmodule

bind acc_exec_unit acc_exec_checker #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_checker (
   .clk        (clk),
   .rst        (rst),
   .op_sel     (op_sel),
   .dest_file  (dest_file),
   .file_addr  (file_addr),
   .alu_result (alu_result),
   .file_we    (file_we),
   .file_waddr (file_waddr),
   .w_reg      (w_reg),
   .flag_c     (flag_c),
   .flag_dc    (flag_dc),
   .flag_z     (flag_z)
);

// File: tb/acc_exec_unit_bench.sv
module acc_exec_unit_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] op_sel = 3'd0;
   logic [7:0] literal = 8'd0;
   logic [6:0] file_addr = 7'd0;
   logic       dest_file = 1'b0;
   logic [7:0] file_rdata = 8'd0;
   logic [7:0] alu_result;
   logic       file_we;
   logic [6:0] file_waddr;
   logic [7:0] file_wdata;
   logic [7:0] w_reg;
   logic       flag_c, flag_dc, flag_z;

   always #2 clk = ~clk;   // 250 MHz

   acc_exec_unit u_acc_exec_unit (
      .clk        (clk),
      .rst        (rst),
      .op_sel     (op_sel),
      .literal    (literal),
      .file_addr  (file_addr),
      .dest_file  (dest_file),
      .file_rdata (file_rdata),
      .alu_result (alu_result),
      .file_we    (file_we),
      .file_waddr (file_waddr),
      .file_wdata (file_wdata),
      .w_reg      (w_reg),
      .flag_c     (flag_c),
      .flag_dc    (flag_dc),
      .flag_z     (flag_z)
   );

   typedef struct {
      logic       real_op;
      logic [7:0] res;
      logic       we;
      logic [6:0] addr;
      logic [7:0] w;
      logic       c, dc, z;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;

   // bench model state
   logic [7:0] m_w  = 8'd0;
   logic       m_c  = 1'b0;
   logic       m_dc = 1'b0;
   logic       m_z  = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, expv);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [7:0] lit, input logic [6:0] fa,
                        input logic d, input logic [7:0] fd, input string tag);
      exp_t       it;
      logic [7:0] opb;
      logic [8:0] s9;
      logic [4:0] s5;
      bit         is_real, is_add, is_file;
      @(posedge clk);
      #1;
      op_sel = op; literal = lit; file_addr = fa; dest_file = d; file_rdata = fd;
      is_real = (op >= 3'd1) && (op <= 3'd4);
      is_add  = (op == 3'd1) || (op == 3'd3);
      is_file = (op == 3'd3) || (op == 3'd4);
      opb = is_file ? fd : lit;
      s9  = {1'b0, m_w} + {1'b0, opb};
      s5  = {1'b0, m_w[3:0]} + {1'b0, opb[3:0]};
      it.real_op = is_real;
      it.res  = is_add ? s9[7:0] : (m_w & opb);
      it.we   = is_real && is_file && d;
      it.addr = fa;
      if (is_real) begin
         if (is_add) begin m_c = s9[8]; m_dc = s5[4]; end
         m_z = (it.res == 8'd0);
         if (!it.we) m_w = it.res;
      end
      it.w = m_w; it.c = m_c; it.dc = m_dc; it.z = m_z;
      it.tag = tag;
      exp_q.push_back(it);
   endtask

   // monitor / scoreboard
   initial begin
      exp_t pend;
      bit   have_pend = 1'b0;
      forever begin
         @(negedge clk);
         if (have_pend) begin
            check(w_reg == pend.w, pend.tag, "w_reg", w_reg, pend.w);
            check(flag_c == pend.c, pend.tag, "flag_c", {7'd0, flag_c}, {7'd0, pend.c});
            check(flag_dc == pend.dc, pend.tag, "flag_dc", {7'd0, flag_dc}, {7'd0, pend.dc});
            check(flag_z == pend.z, pend.tag, "flag_z", {7'd0, flag_z}, {7'd0, pend.z});
            have_pend = 1'b0;
         end
         if (exp_q.size() > 0) begin
            pend = exp_q.pop_front();
            have_pend = 1'b1;
            check(file_we == pend.we, pend.tag, "file_we", {7'd0, file_we}, {7'd0, pend.we});
            if (pend.real_op) begin
               check(alu_result == pend.res, pend.tag, "alu_result", alu_result, pend.res);
            end
            if (pend.we) begin
               check(file_wdata == pend.res, pend.tag, "file_wdata", file_wdata, pend.res);
               check(file_waddr == pend.addr, pend.tag, "file_waddr", {1'b0, file_waddr}, {1'b0, pend.addr});
            end
         end
      end
   end

   // watchdog
   initial begin
      #(4 * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(w_reg == 8'd0, "R1", "w_reg", w_reg, 8'd0);
      check({flag_c, flag_dc, flag_z} == 3'b000, "R1", "flags",
            {5'd0, flag_c, flag_dc, flag_z}, 8'd0);
      check(file_we == 1'b0, "R1", "file_we", {7'd0, file_we}, 8'd0);
      @(posedge clk); #1 rst = 1'b0;

      drive(3'd1, 8'h3C, 7'h00, 1'b0, 8'h00, "R2");
      drive(3'd1, 8'hC4, 7'h00, 1'b0, 8'h00, "R2/R7/R8/R9");   // 3C+C4 = 100
      drive(3'd2, 8'hFF, 7'h00, 1'b0, 8'h00, "R3/R10/R9");     // AND keeps C,DC=1
      drive(3'd1, 8'h08, 7'h00, 1'b0, 8'h00, "R2/R7/R8");
      drive(3'd3, 8'h00, 7'h11, 1'b0, 8'h08, "R4/R8");         // 08+08 = 10, DC
      drive(3'd3, 8'h00, 7'h55, 1'b1, 8'hF5, "R5/R7");         // 10+F5 -> file, C
      drive(3'd4, 8'h00, 7'h22, 1'b0, 8'h30, "R4/R10");
      drive(3'd4, 8'h00, 7'h7F, 1'b1, 8'h0F, "R5/R9/R10");     // 10&0F = 0 -> file
      drive(3'd1, 8'h01, 7'h33, 1'b1, 8'hAA, "R6");            // immediate ignores dest
      drive(3'd2, 8'hF0, 7'h44, 1'b1, 8'hAA, "R6/R3");
      drive(3'd0, 8'h77, 7'h12, 1'b1, 8'h99, "R11");
      drive(3'd7, 8'h77, 7'h12, 1'b1, 8'h99, "R11");
      drive(3'd5, 8'hFF, 7'h01, 1'b0, 8'hFF, "R11");
      drive(3'd2, 8'h00, 7'h00, 1'b0, 8'h00, "R9/R3");
      drive(3'd1, 8'h0F, 7'h00, 1'b0, 8'h00, "R8");            // 00+0F no DC

      lfsr = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         drive(lfsr[2:0], lfsr[15:8], lfsr[9:3], lfsr[4], lfsr[7:0] ^ lfsr[15:8],
               "R2/R4/R7/R8/R9/R10");
      end
      drive(3'd0, 8'h00, 7'h00, 1'b0, 8'h00, "R11");
      repeat (3) @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule